// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog

This block is a down-counting watchdog. Software reaches it through a small word-addressed register file. A single command register takes 16-bit key words. One key opens the configuration registers for writing. Another key refreshes the counter, and a third starts it for good. The configuration registers hold a prescaler code, a 12-bit reload value and a 12-bit window value.

A new configuration value does not reach the counter at once. It is handed over after a fixed number of watchdog ticks, and a status bit shows the hand-over for each register while it is still in progress. The watchdog time base is a one-cycle enable input, `wdg_tick`, that stands in for a slow oscillator.

When the running counter underflows, the block pulses a reset request and reloads itself. It does the same when a refresh arrives while the counter is still above the window value.

Top module: `wdog_keyed_window`

## Requirements
- R1: After reset, the register reads are as follows: the prescaler (offset 0x04) reads 0, the reload (0x08) reads 0xFFF, the window (0x10) reads 0xFFF and the status (0x0C) reads 0. Also after reset, `wdg_count` is 0xFFF and `wdg_rst_req` is low.
- R2: Writing key 0x5555 to bits 15:0 at offset 0x00 unlocks the configuration registers. While they are unlocked, writes update the prescaler (bits 2:0 at 0x04), the reload (bits 11:0 at 0x08) and the window (bits 11:0 at 0x10), and the new values read back.
- R3: While locked, writes to 0x04, 0x08 and 0x10 change nothing. Any command word other than 0x5555 locks the registers again.
- R4: An accepted write sets its status bit: bit 0 for the prescaler, bit 1 for the reload and bit 2 for the window. The bit stays set for exactly 3 watchdog ticks, and only then does the counter use the new value.
- R5: The counter does not move until key 0xCCCC is written. After that, no command word stops it.
- R6: The counter decrements once every 4·2^code ticks, for prescaler codes 0 to 6 (divide by 4 up to 256). Code 7 behaves like code 6.
- R7: When the counter decrements while at 0, `wdg_rst_req` goes high for one clock and the counter reloads and keeps running. With reload value R, the pulses repeat every divisor·(R+1) ticks.
- R8: Key 0xAAAA loads the counter with the active reload value and restarts the prescaler. The next decrement therefore comes a full prescaler period later.
- R9: If the window is not 0xFFF and a 0xAAAA refresh arrives while the running counter is above the window, `wdg_rst_req` pulses in the next cycle. The counter is still reloaded. A refresh while the counter equals the window or is below it raises no request. A window of 0xFFF disables the check.
- R10: The counter and the status-bit hand-over advance only in cycles where `wdg_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wdg_tick | input | 1 | One-cycle watchdog time-base enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data (low half of the register word) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdg_count | output | 12 | Current counter value |
| wdg_rst_req | output | 1 | One-cycle reset request |

## Verification
A lock flag that is wrong shows up on the next read of a configuration register, because that read returns a value that should have been kept out (or one that should have landed). A stuck or early hand-over shows in the status read one tick later. It also shows as the wrong reload value taken on the next refresh. A prescaler or counter error first shows as a drift in `wdg_count` within one prescaler period, and then as a wrong spacing between reset-request pulses. A window compare that is off by one shows in the cycle right after a refresh issued at the boundary count.

// File: rtl/wdog_pkg.sv
// Shared constants for the keyed watchdog: register offsets, key words and
// the status layout. Assumes word-aligned byte offsets on a 5-bit address.
package wdog_pkg;
    localparam int ADDR_W = 5;
    localparam int KEY_W  = 16;

    localparam logic [ADDR_W-1:0] OFS_CMD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PSC = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RLD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WIN = 5'h10;

    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_RUN     = 16'hCCCC;

    // Status bits, LSB first: prescaler, reload, window hand-over busy.
    typedef struct packed {
        logic win_busy;
        logic rld_busy;
        logic psc_busy;
    } wdog_status_t;
endpackage

// File: rtl/wdog_regs.sv
// Register front end: decodes command keys, holds the lock flag and the
// written configuration values. Assumes single-cycle writes with no wait states.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PSC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  wdata,
    output logic [PSC_W-1:0]  psc_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic [CNT_W-1:0]  win_q,
    output logic              psc_wr,
    output logic              rld_wr,
    output logic              win_wr,
    output logic              cmd_refresh,
    output logic              cmd_run
);
    logic unlocked;
    logic cmd_wr;

    // Decode write strobes and one-cycle command pulses.
    always_comb begin
        cmd_wr      = we && (addr == OFS_CMD);
        cmd_refresh = cmd_wr && (wdata == KEY_REFRESH);
        cmd_run     = cmd_wr && (wdata == KEY_RUN);
        psc_wr      = we && unlocked && (addr == OFS_PSC);
        rld_wr      = we && unlocked && (addr == OFS_RLD);
        win_wr      = we && unlocked && (addr == OFS_WIN);
    end

    // Hold the lock flag and the configuration values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            psc_q    <= '0;
            rld_q    <= '1;
            win_q    <= '1;
        end else begin
            if (cmd_wr) unlocked <= (wdata == KEY_OPEN);
            if (psc_wr) psc_q <= wdata[PSC_W-1:0];
            if (rld_wr) rld_q <= wdata[CNT_W-1:0];
            if (win_wr) win_q <= wdata[CNT_W-1:0];
        end
    end

    assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CMD && wdata == KEY_OPEN) |=> unlocked);
    assert_other_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CMD && wdata != KEY_OPEN) |=> !unlocked);
    assert_locked_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(unlocked) |-> ($stable(psc_q) && $stable(rld_q) && $stable(win_q)));
endmodule

// File: rtl/wdog_xfer.sv
// Hand-over slot: after a write, waits SYNC_TICKS watchdog ticks, then
// copies the written value into the active copy. A new write restarts the wait.
module wdog_xfer #(
    parameter int              W          = 12,
    parameter int              SYNC_TICKS = 3,
    parameter logic [W-1:0]    RST_VAL    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] act,
    output logic         busy
);
    localparam int SW = $clog2(SYNC_TICKS + 1);
    logic [SW-1:0] wait_q;

    // Count ticks while busy and commit the value on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            wait_q <= '0;
            act    <= RST_VAL;
        end else if (load) begin
            busy   <= 1'b1;
            wait_q <= '0;
        end else if (busy && tick) begin
            if (wait_q == SW'(SYNC_TICKS - 1)) begin
                act  <= din;
                busy <= 1'b0;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    assert_busy_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
    assert_commit_only_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(act));
    assert_no_tick_no_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !load) |=> busy);
endmodule

// File: rtl/wdog_core.sv
// Counting core: prescaler, down-counter, underflow and window check.
// Assumes refresh and run pulses are never asserted in the same cycle.
module wdog_core #(
    parameter int CNT_W         = 12,
    parameter int PSC_W         = 3,
    parameter int DIV_BASE_LOG2 = 2,
    parameter int DIV_MAX_CODE  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PSC_W-1:0] psc_act,
    input  logic [CNT_W-1:0] rld_act,
    input  logic [CNT_W-1:0] win_act,
    input  logic             cmd_refresh,
    input  logic             cmd_run,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);
    localparam int DIV_W = DIV_BASE_LOG2 + DIV_MAX_CODE;

    logic             running;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic [PSC_W-1:0] code_eff;
    logic             win_on;

    // Clamp the prescaler code and derive the divider's last count.
    always_comb begin
        code_eff = (psc_act > PSC_W'(DIV_MAX_CODE)) ? PSC_W'(DIV_MAX_CODE) : psc_act;
        div_lim  = DIV_W'((1 << (int'(code_eff) + DIV_BASE_LOG2)) - 1);
        win_on   = (win_act != '1);
    end

    // Run the prescaler and counter, and raise the one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            div_q   <= '0;
            cnt     <= '1;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (cmd_run) running <= 1'b1;
            if (cmd_refresh) begin
                div_q <= '0;
                cnt   <= rld_act;
                if (running && win_on && (cnt > win_act)) rst_req <= 1'b1;
            end else if (running && tick) begin
                if (div_q >= div_lim) begin
                    div_q <= '0;
                    if (cnt == '0) begin
                        rst_req <= 1'b1;
                        cnt     <= rld_act;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
    assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd_refresh) |=> $stable(cnt));
    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cmd_refresh) && !rst_req) |->
            ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) - 1'b1))));
    assert_req_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == $past(rld_act)));
    assert_req_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(running));
endmodule

// File: rtl/wdog_keyed_window.sv
// Top of the keyed windowed watchdog: register front end, three hand-over
// slots and the counting core. Assumes wdg_tick is a single-cycle enable.
module wdog_keyed_window
    import wdog_pkg::*;
#(
    parameter int CNT_W         = 12,
    parameter int PSC_W         = 3,
    parameter int SYNC_TICKS    = 3,
    parameter int DIV_BASE_LOG2 = 2,
    parameter int DIV_MAX_CODE  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdg_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [CNT_W-1:0]  wdg_count,
    output logic              wdg_rst_req
);
    logic [PSC_W-1:0] psc_q, psc_act;
    logic [CNT_W-1:0] rld_q, rld_act, win_q, win_act;
    logic             psc_wr, rld_wr, win_wr, cmd_refresh, cmd_run;
    wdog_status_t     sts;

    wdog_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .psc_q(psc_q), .rld_q(rld_q), .win_q(win_q),
        .psc_wr(psc_wr), .rld_wr(rld_wr), .win_wr(win_wr),
        .cmd_refresh(cmd_refresh), .cmd_run(cmd_run)
    );

    wdog_xfer #(.W(PSC_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_xfer_psc (
        .clk(clk), .rst_n(rst_n), .tick(wdg_tick), .load(psc_wr), .din(psc_q),
        .act(psc_act), .busy(sts.psc_busy)
    );
    wdog_xfer #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_xfer_rld (
        .clk(clk), .rst_n(rst_n), .tick(wdg_tick), .load(rld_wr), .din(rld_q),
        .act(rld_act), .busy(sts.rld_busy)
    );
    wdog_xfer #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_xfer_win (
        .clk(clk), .rst_n(rst_n), .tick(wdg_tick), .load(win_wr), .din(win_q),
        .act(win_act), .busy(sts.win_busy)
    );

    wdog_core #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DIV_BASE_LOG2(DIV_BASE_LOG2),
                .DIV_MAX_CODE(DIV_MAX_CODE)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(wdg_tick),
        .psc_act(psc_act), .rld_act(rld_act), .win_act(win_act),
        .cmd_refresh(cmd_refresh), .cmd_run(cmd_run),
        .cnt(wdg_count), .rst_req(wdg_rst_req)
    );

    // Return the addressed register, zero-extended; unmapped offsets read 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PSC: bus_rdata = 32'(psc_q);
            OFS_RLD: bus_rdata = 32'(rld_q);
            OFS_STS: bus_rdata = 32'(sts);
            OFS_WIN: bus_rdata = 32'(win_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/tb_wdog_keyed_window.sv
module tb_wdog_keyed_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdg_tick = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] wdg_count;
    logic        wdg_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_keyed_window dut (
        .clk(clk), .rst_n(rst_n), .wdg_tick(wdg_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_count(wdg_count), .wdg_rst_req(wdg_rst_req)
    );

    localparam int VEC_N = 6;
    localparam logic [2:0]  T_PSC [VEC_N] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
    localparam logic [11:0] T_RLD [VEC_N] = '{12'd3, 12'd2, 12'd1, 12'd0, 12'd1, 12'd0};
    localparam int          T_PER [VEC_N] = '{16, 24, 32, 32, 512, 256};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Caller is at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] c0;
        int n;
        step(4);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        rd(5'h04, v); check("R1 psc", v, 0);
        rd(5'h08, v); check("R1 rld", v, 32'hFFF);
        rd(5'h10, v); check("R1 win", v, 32'hFFF);
        rd(5'h0C, v); check("R1 sts", v, 0);
        check("R1 count", 32'(wdg_count), 32'hFFF);
        check("R1 req", 32'(wdg_rst_req), 0);

        // R3 locked writes ignored
        wr(5'h08, 16'h0123); rd(5'h08, v); check("R3 locked rld", v, 32'hFFF);
        wr(5'h04, 16'h0003); rd(5'h04, v); check("R3 locked psc", v, 0);
        rd(5'h0C, v); check("R3 no busy", v, 0);

        // R2 unlock and write; R4 busy bit for exactly 3 ticks
        wr(5'h00, 16'h5555);
        wr(5'h08, 16'h0005);
        rd(5'h0C, v); check("R4 busy tick0", v, 32'h2);
        step(2); rd(5'h0C, v); check("R4 busy tick2", v, 32'h2);
        step(1); rd(5'h0C, v); check("R4 busy clear", v, 0);
        rd(5'h08, v); check("R2 rld readback", v, 32'h5);

        // R3 other key relocks
        wr(5'h00, 16'h1234);
        wr(5'h08, 16'h0007); rd(5'h08, v); check("R3 relocked rld", v, 32'h5);

        // R5 counter idle before start
        check("R5 idle count", 32'(wdg_count), 32'hFFF);

        // R4/R10 value not used while busy, busy held with no tick
        wdg_tick = 1'b0;
        wr(5'h00, 16'h5555);
        wr(5'h08, 16'h0030);
        step(5);
        rd(5'h0C, v); check("R10 busy held", v, 32'h2);
        wr(5'h00, 16'hAAAA);
        check("R4 old value used", 32'(wdg_count), 32'h5);
        wdg_tick = 1'b1;
        step(3);
        rd(5'h0C, v); check("R4 busy after ticks", v, 0);
        wr(5'h00, 16'hAAAA);
        check("R8 new value used", 32'(wdg_count), 32'h30);
        step(20);
        check("R5 still idle", 32'(wdg_count), 32'h30);

        // R5/R6 start, divide by 4
        wr(5'h00, 16'hCCCC);
        step(8);
        check("R6 two decrements", 32'(wdg_count), 32'h2E);

        // R5 cannot stop
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'h1234);
        c0 = wdg_count;
        step(8);
        check("R5 keeps running", 32'(wdg_count != c0), 1);

        // R6/R7/R8 table of prescaler and reload vectors
        for (int i = 0; i < VEC_N; i++) begin
            wr(5'h00, 16'h5555);
            wr(5'h04, 16'(T_PSC[i]));
            wr(5'h08, 16'(T_RLD[i]));
            rd(5'h04, v); check("R2 psc readback", v, 32'(T_PSC[i]));
            bus_addr = 5'h00;
            step(4);
            wr(5'h00, 16'hAAAA);
            n = 0;
            while (!wdg_rst_req && n < 2000) begin
                step(1);
                n++;
            end
            check("R8 refresh to request", n, T_PER[i]);
            n = 0;
            do begin
                step(1);
                n++;
            end while (!wdg_rst_req && n < 2000);
            check("R7 request period", n, T_PER[i]);
            check("R7 reload on underflow", 32'(wdg_count), 32'(T_RLD[i]));
        end

        // R9 window
        wr(5'h00, 16'h5555);
        wr(5'h04, 16'h0000);
        wr(5'h08, 16'd40);
        step(4);
        wr(5'h00, 16'hAAAA);
        check("R9 window off no req", 32'(wdg_rst_req), 0);
        wr(5'h00, 16'h5555);
        wr(5'h10, 16'd10);
        rd(5'h10, v); check("R2 win readback", v, 32'd10);
        bus_addr = 5'h00;
        step(4);
        wr(5'h00, 16'hAAAA);
        check("R9 early req", 32'(wdg_rst_req), 1);
        check("R9 early reloads", 32'(wdg_count), 32'd40);
        n = 0;
        while (wdg_count != 12'd11 && n < 2000) begin step(1); n++; end
        wr(5'h00, 16'hAAAA);
        check("R9 above by one req", 32'(wdg_rst_req), 1);
        n = 0;
        while (wdg_count != 12'd10 && n < 2000) begin step(1); n++; end
        wr(5'h00, 16'hAAAA);
        check("R9 at window no req", 32'(wdg_rst_req), 0);
        check("R9 at window reload", 32'(wdg_count), 32'd40);

        // R10 no tick, no counting
        wdg_tick = 1'b0;
        c0 = wdg_count;
        step(20);
        check("R10 frozen count", 32'(wdg_count), 32'(c0));
        check("R10 no req", 32'(wdg_rst_req), 0);
        wdg_tick = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule